// File: doc/BRIEF.md
# OTP Fuse Array Register Front End

This block is a memory-mapped register front end for a one-time-programmable fuse array. Software controls the fuse macro through a bank of fifteen 32-bit word registers. Fourteen of them are plain read/write control registers: fuse index, IO select, address strobe, chip enable, clock, data-in, data strobe, program, test control, test mode, test-mode repair, test read, trim and write enable. The fifteenth is a read-only data-out register. It returns the fuse word at the selected index, but only when the fuse macro is fully enabled.

The fuse contents are fixed at reset. Every word reads in the erased, all-ones state, except two words near the top of the low page. One holds a serial number taken from a parameter. The next holds that number's bitwise complement, so software can check that the serial is valid. Burning fuses is not modelled.

The block sits on a simple register bus. The bus carries a byte address, a size code, read and write strobes, write data that may be wider than 32 bits, a registered read-data return and a one-cycle error pulse for bad accesses.

Top module: `otp_fuse_regif`

## Requirements
- R1: After reset, every control register reads zero. Data-out reads 0x000000FF because all three enables are clear.
- R2: The control registers sit at byte offsets 0x00 through 0x38 in steps of 4. The order is: index (0x00), IO select (0x04), address strobe (0x08), chip enable (0x0C), clock (0x10), data-in (0x14), data-out (0x18), data strobe (0x1C), program (0x20), test control (0x24), test mode (0x28), test-mode repair (0x2C), test read (0x30), trim (0x34) and write enable (0x38). Each register other than data-out reads back exactly the 32-bit value last written to it.
- R3: A write to the index register keeps only bits 11:0. A readback of that register shows bits 31:12 as zero.
- R4: A write to data-out (0x18) changes no register. It raises no error.
- R5: A read of data-out returns the fuse word at the stored index only when bit 0 is set in all three of chip enable, data strobe and trim. In every other case it returns 0x000000FF, whatever the other bits of those registers hold.
- R6: Every fuse word other than the two serial words reads 0xFFFFFFFF.
- R7: The fuse word at index 0xFC holds the serial parameter. The word at index 0xFD holds its bitwise complement.
- R8: Only 4-byte accesses are performed, that is size code 2. The size codes are 0 for 1 byte, 1 for 2 bytes and 3 for 8 bytes. An access of any other size is handled as unmapped. Write data bits above bit 31 are discarded.
- R9: An access is unmapped if its offset is above 0x38, is not word aligned, or has the wrong size. An unmapped read returns zero. An unmapped write changes no register. Either kind raises busErr for exactly one cycle, on the cycle after the strobe.
- R10: Read data appears on busRdata on the cycle after the read strobe. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 12 | Byte address of the access |
| busSize | input | 2 | Access size code (2 = 4 bytes) |
| busRead | input | 1 | Read strobe |
| busWrite | input | 1 | Write strobe |
| busWdata | input | 64 | Write data; only bits 31:0 are used |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The hardest case to reach is a data-out read that actually returns fuse contents. That needs three separate enable registers to have bit 0 set and the index register pointing at one of the two serial slots. The fallback case is just as hard to isolate, because only bit 0 of each enable register counts. The stimulus therefore programs all three enables and both serial indices. It then clears one enable at a time, while leaving every other bit of that register set, so the fallback to 0x000000FF is tied to bit 0 alone. Oversized index writes and writes with non-zero upper data bits check that the dropped bits never reach the fuse selection.

// File: rtl/otp_regif_pkg.sv
package otp_regif_pkg;
  localparam int REG_COUNT = 15;
  localparam int SEL_W = 4;
  localparam int WORD_W = 32;

  localparam logic [SEL_W-1:0] SEL_INDEX   = 4'd0;
  localparam logic [SEL_W-1:0] SEL_CHIPEN  = 4'd3;
  localparam logic [SEL_W-1:0] SEL_DOUT    = 4'd6;
  localparam logic [SEL_W-1:0] SEL_DATASTB = 4'd7;
  localparam logic [SEL_W-1:0] SEL_TRIM    = 4'd13;
  localparam logic [SEL_W-1:0] SEL_LAST    = 4'(REG_COUNT - 1);

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef struct packed {
    logic rdEn;
    logic wrEn;
    logic hit;
    logic [SEL_W-1:0] sel;
  } regStrobe_t;
endpackage

// File: rtl/otp_regif_ctrl.sv
module otp_regif_ctrl
  import otp_regif_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busRead,
  input  logic              busWrite,
  output regStrobe_t        strb,
  output logic              busErr
);
  logic aligned;
  logic inRange;
  logic sizeOk;
  logic errQ;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign inRange = (busAddr[ADDR_W-1:6] == '0) && (busAddr[5:2] <= SEL_LAST);
  assign sizeOk  = (busSize == SIZE_WORD);

  always_comb begin
    strb.rdEn = busRead;
    strb.wrEn = busWrite;
    strb.hit  = aligned && inRange && sizeOk;
    strb.sel  = busAddr[5:2];
  end

  always_ff @(posedge clk) begin
    if (rst) errQ <= 1'b0;
    else     errQ <= (busRead || busWrite) && !strb.hit;
  end

  assign busErr = errQ;

  // R9
  err_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.hit && !busErr) |=> !busErr);

  // R9
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (busErr && !(busRead || busWrite)) |=> !busErr);
endmodule

// File: rtl/otp_regif_datapath.sv
module otp_regif_datapath
  import otp_regif_pkg::*;
#(
  parameter int          FUSE_IDX_W = 12,
  parameter int          SERIAL_IDX = 'hFC,
  parameter logic [31:0] SERIAL     = 32'hA5C3_0F17,
  parameter int          EN_BIT     = 0,
  parameter int          BUS_W      = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  regStrobe_t        strb,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [WORD_W-1:0] busRdata
);
  localparam logic [WORD_W-1:0] IDX_MASK   = (32'd1 << FUSE_IDX_W) - 32'd1;
  localparam logic [WORD_W-1:0] FALLBACK   = 32'h0000_00FF;
  localparam logic [WORD_W-1:0] ERASED     = '1;
  localparam logic [FUSE_IDX_W-1:0] SER_LO = FUSE_IDX_W'(SERIAL_IDX);
  localparam logic [FUSE_IDX_W-1:0] SER_HI = FUSE_IDX_W'(SERIAL_IDX + 1);

  logic [REG_COUNT-1:0][WORD_W-1:0] regs;
  logic [WORD_W-1:0]     wrWord;
  logic                  unusedHigh;
  logic [FUSE_IDX_W-1:0] fuseIdx;
  logic [WORD_W-1:0]     fuseWord;
  logic                  macroOn;
  logic [WORD_W-1:0]     rdNext;
  logic [WORD_W-1:0]     rdataQ;

  assign wrWord     = busWdata[WORD_W-1:0];
  assign unusedHigh = ^busWdata[BUS_W-1:WORD_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (strb.wrEn && strb.hit && strb.sel != SEL_DOUT) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (strb.sel == SEL_W'(i)) begin
          regs[i] <= (SEL_W'(i) == SEL_INDEX) ? (wrWord & IDX_MASK) : wrWord;
        end
      end
    end
  end

  assign fuseIdx = regs[SEL_INDEX][FUSE_IDX_W-1:0];

  always_comb begin
    if (fuseIdx == SER_LO)      fuseWord = SERIAL;
    else if (fuseIdx == SER_HI) fuseWord = ~SERIAL;
    else                        fuseWord = ERASED;
  end

  assign macroOn = regs[SEL_CHIPEN][EN_BIT] && regs[SEL_DATASTB][EN_BIT]
                && regs[SEL_TRIM][EN_BIT];

  always_comb begin
    if (!strb.hit)                rdNext = '0;
    else if (strb.sel == SEL_DOUT) rdNext = macroOn ? fuseWord : FALLBACK;
    else                          rdNext = regs[strb.sel];
  end

  always_ff @(posedge clk) begin
    if (rst)            rdataQ <= '0;
    else if (strb.rdEn) rdataQ <= rdNext;
  end

  assign busRdata = rdataQ;

  // R5
  dout_fallback_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.hit && strb.sel == SEL_DOUT && !regs[SEL_CHIPEN][EN_BIT])
      |=> busRdata == FALLBACK);

  // R3
  index_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && strb.hit && strb.sel == SEL_INDEX)
      |=> (busRdata >> FUSE_IDX_W) == '0);

  // R4
  dout_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && strb.hit && strb.sel == SEL_DOUT) |=> $stable(regs));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && !strb.hit) |=> $stable(regs));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && !strb.hit) |=> busRdata == '0);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.rdEn |=> $stable(busRdata));
endmodule

// File: rtl/otp_fuse_regif.sv
module otp_fuse_regif
  import otp_regif_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          BUS_W      = 64,
  parameter int          FUSE_IDX_W = 12,
  parameter int          SERIAL_IDX = 'hFC,
  parameter logic [31:0] SERIAL     = 32'hA5C3_0F17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr
);
  regStrobe_t strb;

  otp_regif_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busSize(busSize),
    .busRead(busRead), .busWrite(busWrite), .strb(strb), .busErr(busErr)
  );

  otp_regif_datapath #(
    .FUSE_IDX_W(FUSE_IDX_W), .SERIAL_IDX(SERIAL_IDX), .SERIAL(SERIAL),
    .EN_BIT(0), .BUS_W(BUS_W)
  ) dp_i (
    .clk(clk), .rst(rst), .strb(strb), .busWdata(busWdata), .busRdata(busRdata)
  );
endmodule

// File: tb/otp_fuse_regif_tb.sv
module otp_fuse_regif_tb_top;
  localparam logic [31:0] SER = 32'h3C96_E12B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] busAddr = '0;
  logic [1:0]  busSize = 2'd2;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [63:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;

  int checks = 0;
  int errors = 0;
  logic [31:0] mreg [15];
  logic [31:0] expRd = '0;
  logic        expErr = 1'b0;

  always #10 clk = ~clk;

  otp_fuse_regif #(.SERIAL(SER)) dut_i (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busSize(busSize),
    .busRead(busRead), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .busErr(busErr)
  );

  function automatic bit mHit(logic [11:0] a, logic [1:0] sz);
    return sz == 2'd2 && a[1:0] == 2'b00 && a <= 12'h038;
  endfunction

  function automatic logic [31:0] mFuse(logic [11:0] idx);
    if (idx == 12'h0FC) return SER;
    if (idx == 12'h0FD) return ~SER;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a);
    int s = int'(a[5:2]);
    if (s == 6) begin
      if (mreg[3][0] && mreg[7][0] && mreg[13][0]) return mFuse(mreg[0][11:0]);
      return 32'h0000_00FF;
    end
    return mreg[s];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit rd, bit wr, logic [11:0] a,
                      logic [1:0] sz, logic [63:0] d);
    bit h;
    busRead = rd; busWrite = wr; busAddr = a; busSize = sz; busWdata = d;
    @(posedge clk);
    h = mHit(a, sz);
    if (rd) expRd = h ? mRead(a) : 32'h0;
    expErr = (rd || wr) && !h;
    if (wr && h && a[5:2] != 4'd6)
      mreg[a[5:2]] = (a[5:2] == 4'd0) ? (d[31:0] & 32'h0000_0FFF) : d[31:0];
    @(negedge clk);
    check({tag, " rdata"}, busRdata, expRd);
    check({tag, " err"}, {31'b0, busErr}, {31'b0, expErr});
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 12'h0, 2'd2, 64'h0);
  endtask

  task automatic wr32(string tag, logic [11:0] a, logic [63:0] d);
    step(tag, 0, 1, a, 2'd2, d);
  endtask

  task automatic rd32(string tag, logic [11:0] a);
    step(tag, 1, 0, a, 2'd2, 64'h0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 15; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset rdata", busRdata, 32'h0);
    check("R1 reset err", {31'b0, busErr}, 32'h0);

    // R1: all registers zero, data-out falls back
    for (int i = 0; i < 15; i++) rd32("R1", 12'(i * 4));

    // R2 / R8: readback with upper write data bits set
    for (int i = 0; i < 15; i++)
      wr32("R2", 12'(i * 4), {32'hDEAD_BEEF, 32'h5A5A_5A5A ^ (32'h0101_0101 * i)});
    for (int i = 0; i < 15; i++) rd32("R2", 12'(i * 4));
    idle("R10 hold");
    idle("R10 hold");

    // R3: index mask
    wr32("R3", 12'h000, 64'hFFFF_FFFF_FFFF_FFFF);
    rd32("R3", 12'h000);
    wr32("R3", 12'h000, 64'h0000_0000_1234_5ABC);
    rd32("R3", 12'h000);

    // R4: data-out write ignored
    wr32("R4", 12'h018, 64'h0000_0000_0000_0000);
    for (int i = 0; i < 15; i++) rd32("R4", 12'(i * 4));

    // R5 / R7: full enable, serial words
    wr32("R5", 12'h00C, 64'h1);
    wr32("R5", 12'h01C, 64'h1);
    wr32("R5", 12'h034, 64'h1);
    wr32("R7", 12'h000, 64'h0FC);
    rd32("R7", 12'h018);
    wr32("R7", 12'h000, 64'h0FD);
    rd32("R7", 12'h018);
    // R6: erased words
    wr32("R6", 12'h000, 64'h010);
    rd32("R6", 12'h018);
    wr32("R6", 12'h000, 64'hFFF);
    rd32("R6", 12'h018);
    wr32("R6", 12'h000, 64'h0FB);
    rd32("R6", 12'h018);
    // R5: clear each enable bit 0 in turn, other bits set
    wr32("R5", 12'h000, 64'h0FC);
    wr32("R5", 12'h00C, 64'hFFFF_FFFE);
    rd32("R5", 12'h018);
    wr32("R5", 12'h00C, 64'h1);
    wr32("R5", 12'h01C, 64'hFFFF_FFFE);
    rd32("R5", 12'h018);
    wr32("R5", 12'h01C, 64'h1);
    wr32("R5", 12'h034, 64'hFFFF_FFFE);
    rd32("R5", 12'h018);
    wr32("R5", 12'h034, 64'hFFFF_FFFF);
    rd32("R5", 12'h018);

    // R8: wrong sizes
    step("R8", 0, 1, 12'h00C, 2'd1, 64'h0);
    step("R8", 0, 1, 12'h00C, 2'd3, 64'h0);
    rd32("R8", 12'h00C);
    step("R8", 1, 0, 12'h00C, 2'd0, 64'h0);
    idle("R8");
    rd32("R8", 12'h018);

    // R9: unmapped offsets
    rd32("R9", 12'h03C);
    idle("R9");
    rd32("R9", 12'h004);
    rd32("R9", 12'h7FC);
    wr32("R9", 12'h03C, 64'h1234);
    wr32("R9", 12'h005, 64'h1234);
    wr32("R9", 12'h044, 64'h1234);
    idle("R9");
    for (int i = 0; i < 15; i++) rd32("R9", 12'(i * 4));

    // R10: back-to-back reads and hold
    rd32("R10", 12'h014);
    rd32("R10", 12'h020);
    idle("R10");
    idle("R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule